// File: doc/BRIEF.md
# Front-End Command Decoder with Block Transfers

This block sits behind the command deserializer of a front-end board. It takes 10-bit command words and decodes them. The low five bits are the opcode and the high five bits are an address or information field. Run-time commands with bit 4 clear become one-cycle strobes: buffer clear, timing resync, level-1 accept, read event and calibration strobe. Commands with bit 4 set are register accesses to one of three register groups. They are presented on a plain address, data and strobe memory port. Each read word also raises a request toward the readout formatter.

Block transfers use a next-transfer address and a word counter. Both live in group 2 and are loaded by single-word writes before the transfer starts. A block write takes one 16-bit data word per transfer. Each word goes to the current next-transfer address, after which the address increments and the counter decrements. A block read streams one word per clock until the counter is exhausted. Three data-less group 2 reads act as reset commands rather than reads: they reset the test-pattern read pointer, the event-buffer read pointer, or the whole board.

Top module: `fecmd_top`

## Requirements
- R1: Out of reset every strobe output is low, `ntaValue` and `wcValue` are zero and `blkWrErr` is low.
- R2: A command with bit 4 clear and bits 3..0 equal to 1, 2, 3, 4 or 5 pulses `runClear`, `runSync`, `runTrigger`, `runReadEvent` or `runCalStrobe` respectively for one cycle, in the cycle after `cmdValid`. Values 0 and 6..15 produce no output.
- R3: With bit 4 set, bit 3 selects write (1) or read (0), bit 2 selects block (1) or single (0), and bits 1..0 select group 0, 1 or 2. Group value 3 is ignored.
- R4: A single write waits for the next `dataValid`. In the cycle after that word it drives `memStb`=1 and `memWe`=1, with `memGroup` from the command, `memAddr` equal to the command's 5-bit field zero-extended, and `memWdata` equal to the data word.
- R5: A single read drives `memStb`=1, `memWe`=0, `rdReq`=1 and `rdLast`=1 for one cycle after the command, with the group and the zero-extended field as address. When no access is in progress, every memory-port output is zero.
- R6: A single write to group 2 field 2 loads `ntaValue` from data bits 7..0. A single write to group 2 field 3 loads `wcValue` from data bits 8..0. Neither write strobes the memory port.
- R7: In a block write, each `dataValid` word is written to address `ntaValue` in the following cycle. After that write the address increments by one, wrapping from 255 to 0, and the counter decrements by one. The transfer ends when the counter reaches zero.
- R8: A block write issued while `wcValue` is zero writes nothing and sets `blkWrErr`. The flag stays set until a board reset.
- R9: A block read issued with counter N>0 emits N read words on consecutive cycles, starting the cycle after the command. The words use incrementing addresses starting at `ntaValue`, and `rdLast` is high only on the final word. With N=0 the block read emits nothing.
- R10: A group 2 single read (bits 4..0 = 10010) with field 0x0C pulses `tpPtrRst` and with field 0x18 pulses `evPtrRst`; with field 0x1F it pulses `boardRst` and clears `ntaValue`, `wcValue` and `blkWrErr`. None of these three performs a read.
- R11: While a write is waiting for data or a block transfer is running, `cmdValid` is ignored. While idle, `dataValid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cmdValid | input | 1 | Command word present |
| cmdWord | input | 10 | Field in 9..5, opcode in 4..0 |
| dataValid | input | 1 | Data word present |
| dataWord | input | 16 | Write data word |
| runClear | output | 1 | Buffer clear strobe |
| runSync | output | 1 | Timing resync strobe |
| runTrigger | output | 1 | Level-1 accept strobe |
| runReadEvent | output | 1 | Read event strobe |
| runCalStrobe | output | 1 | Calibration strobe |
| memStb | output | 1 | Register/memory access strobe |
| memWe | output | 1 | Access is a write |
| memGroup | output | 2 | Register group of the access |
| memAddr | output | 8 | Access address |
| memWdata | output | 16 | Write data |
| rdReq | output | 1 | One read word for the formatter |
| rdLast | output | 1 | Final word of the read |
| tpPtrRst | output | 1 | Test-pattern read pointer reset |
| evPtrRst | output | 1 | Event-buffer read pointer reset |
| boardRst | output | 1 | Whole-board reset strobe |
| ntaValue | output | 8 | Next-transfer address |
| wcValue | output | 9 | Word counter |
| blkWrErr | output | 1 | Block write refused with empty counter |

## Verification
The stimulus targets four corner cases.

- The next-transfer address is walked across its 255-to-0 wrap during a block write. A design without the wrap would write to an address above the 8-bit range, or would stop short.
- Block transfers are started with a counter of zero and with a counter of one. A design that tests the counter after decrementing would underflow to 511 and stream hundreds of words, or would drop `rdLast` on a single-word read.
- Commands and stray data words are offered while a write waits and while a read streams. A decoder that accepts them would emit extra strobes or corrupt the transfer.
- All sixteen run-time codes are issued. A loose decode would pulse a run strobe on a reserved value.

// File: rtl/fecmd_pkg.sv
package fecmd_pkg;

  localparam int OP_W  = 5;
  localparam int FLD_W = 5;
  localparam int CMD_W = OP_W + FLD_W;
  localparam int RUN_N = 5;

  localparam logic [1:0] GRP_SYS  = 2'd2;
  localparam logic [1:0] GRP_NONE = 2'd3;

  localparam logic [FLD_W-1:0] FLD_NTA     = 5'd2;
  localparam logic [FLD_W-1:0] FLD_WC      = 5'd3;
  localparam logic [FLD_W-1:0] FLD_TP_RST  = 5'h0C;
  localparam logic [FLD_W-1:0] FLD_EV_RST  = 5'h18;
  localparam logic [FLD_W-1:0] FLD_BRD_RST = 5'h1F;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_ONE,
    ST_WR_BLK,
    ST_RD_BLK
  } seq_state_t;

  // strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic [RUN_N-1:0] runStb;
    logic             memStb;
    logic             memWe;
    logic             useNta;
    logic             rdReq;
    logic             rdLast;
    logic             loadNta;
    logic             loadWc;
    logic             step;
    logic             setErr;
    logic             tpRst;
    logic             evRst;
    logic             brdRst;
  } ctrl_stb_t;

endpackage

// File: rtl/fecmd_ctrl.sv
module fecmd_ctrl
  import fecmd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdWord,
  input  logic             dataValid,
  input  logic             wcZero,
  input  logic             wcOne,
  output ctrl_stb_t        stb,
  output logic [1:0]       opGrp,
  output logic [FLD_W-1:0] opAddr
);

  logic [OP_W-1:0]  opc;
  logic [FLD_W-1:0] fld;
  logic             isSpec, isWrite, isBlock;
  logic [1:0]       grp;

  seq_state_t       state, nxtState;
  logic [1:0]       latGrp, nxtGrp;
  logic [FLD_W-1:0] latAddr, nxtAddr;

  assign opc     = cmdWord[OP_W-1:0];
  assign fld     = cmdWord[CMD_W-1:OP_W];
  assign isSpec  = opc[4];
  assign isWrite = opc[3];
  assign isBlock = opc[2];
  assign grp     = opc[1:0];

  always_comb begin
    stb      = '0;
    nxtState = state;
    nxtGrp   = latGrp;
    nxtAddr  = latAddr;
    opGrp    = latGrp;
    opAddr   = latAddr;
    case (state)
      ST_IDLE: begin
        opGrp  = grp;
        opAddr = fld;
        if (cmdValid) begin
          if (!isSpec) begin
            if (opc[3:0] != 4'd0 && opc[3:0] <= 4'd5)
              stb.runStb = 5'b00001 << (opc[3:0] - 4'd1);
          end else if (grp != GRP_NONE) begin
            nxtGrp  = grp;
            nxtAddr = fld;
            case ({isWrite, isBlock})
              2'b00: begin
                if (grp == GRP_SYS && fld == FLD_TP_RST)
                  stb.tpRst = 1'b1;
                else if (grp == GRP_SYS && fld == FLD_EV_RST)
                  stb.evRst = 1'b1;
                else if (grp == GRP_SYS && fld == FLD_BRD_RST)
                  stb.brdRst = 1'b1;
                else begin
                  stb.memStb = 1'b1;
                  stb.rdReq  = 1'b1;
                  stb.rdLast = 1'b1;
                end
              end
              2'b10: nxtState = ST_WAIT_ONE;
              2'b01: begin
                if (!wcZero) begin
                  stb.memStb = 1'b1;
                  stb.useNta = 1'b1;
                  stb.rdReq  = 1'b1;
                  stb.rdLast = wcOne;
                  stb.step   = 1'b1;
                  if (!wcOne) nxtState = ST_RD_BLK;
                end
              end
              default: begin
                if (wcZero) stb.setErr = 1'b1;
                else        nxtState   = ST_WR_BLK;
              end
            endcase
          end
        end
      end
      ST_WAIT_ONE: begin
        if (dataValid) begin
          if (latGrp == GRP_SYS && latAddr == FLD_NTA)
            stb.loadNta = 1'b1;
          else if (latGrp == GRP_SYS && latAddr == FLD_WC)
            stb.loadWc = 1'b1;
          else begin
            stb.memStb = 1'b1;
            stb.memWe  = 1'b1;
          end
          nxtState = ST_IDLE;
        end
      end
      ST_WR_BLK: begin
        if (dataValid) begin
          stb.memStb = 1'b1;
          stb.memWe  = 1'b1;
          stb.useNta = 1'b1;
          stb.step   = 1'b1;
          if (wcOne) nxtState = ST_IDLE;
        end
      end
      default: begin
        stb.memStb = 1'b1;
        stb.useNta = 1'b1;
        stb.rdReq  = 1'b1;
        stb.rdLast = wcOne;
        stb.step   = 1'b1;
        if (wcOne) nxtState = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      latGrp  <= '0;
      latAddr <= '0;
    end else begin
      state   <= nxtState;
      latGrp  <= nxtGrp;
      latAddr <= nxtAddr;
    end
  end

endmodule

// File: rtl/fecmd_dpath.sv
module fecmd_dpath
  import fecmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WC_W   = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_stb_t         stb,
  input  logic [1:0]        opGrp,
  input  logic [FLD_W-1:0]  opAddr,
  input  logic [DATA_W-1:0] dataWord,
  output logic [RUN_N-1:0]  runStb,
  output logic              memStb,
  output logic              memWe,
  output logic [1:0]        memGroup,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rdReq,
  output logic              rdLast,
  output logic              tpPtrRst,
  output logic              evPtrRst,
  output logic              boardRst,
  output logic [ADDR_W-1:0] ntaValue,
  output logic [WC_W-1:0]   wcValue,
  output logic              blkWrErr,
  output logic              wcZero,
  output logic              wcOne
);

  localparam int                ADDR_PAD = ADDR_W - FLD_W;
  localparam logic [WC_W-1:0]   WC_UNIT  = {{(WC_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] NTA_UNIT = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] nta;
  logic [WC_W-1:0]   wc;
  logic [ADDR_W-1:0] accAddr;

  assign wcZero  = (wc == '0);
  assign wcOne   = (wc == WC_UNIT);
  assign accAddr = stb.useNta ? nta : {{ADDR_PAD{1'b0}}, opAddr};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runStb   <= '0;
      memStb   <= 1'b0;
      memWe    <= 1'b0;
      memGroup <= '0;
      memAddr  <= '0;
      memWdata <= '0;
      rdReq    <= 1'b0;
      rdLast   <= 1'b0;
      tpPtrRst <= 1'b0;
      evPtrRst <= 1'b0;
      boardRst <= 1'b0;
      nta      <= '0;
      wc       <= '0;
      blkWrErr <= 1'b0;
    end else begin
      runStb   <= stb.runStb;
      memStb   <= stb.memStb;
      memWe    <= stb.memWe;
      memGroup <= stb.memStb ? opGrp : 2'd0;
      memAddr  <= stb.memStb ? accAddr : '0;
      memWdata <= stb.memWe ? dataWord : '0;
      rdReq    <= stb.rdReq;
      rdLast   <= stb.rdLast;
      tpPtrRst <= stb.tpRst;
      evPtrRst <= stb.evRst;
      boardRst <= stb.brdRst;

      if (stb.brdRst)       nta <= '0;
      else if (stb.loadNta) nta <= dataWord[ADDR_W-1:0];
      else if (stb.step)    nta <= nta + NTA_UNIT;

      if (stb.brdRst)       wc <= '0;
      else if (stb.loadWc)  wc <= dataWord[WC_W-1:0];
      else if (stb.step)    wc <= wc - WC_UNIT;

      if (stb.brdRst)       blkWrErr <= 1'b0;
      else if (stb.setErr)  blkWrErr <= 1'b1;
    end
  end

  assign ntaValue = nta;
  assign wcValue  = wc;

endmodule

// File: rtl/fecmd_top.sv
module fecmd_top
  import fecmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WC_W   = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [9:0]        cmdWord,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataWord,
  output logic              runClear,
  output logic              runSync,
  output logic              runTrigger,
  output logic              runReadEvent,
  output logic              runCalStrobe,
  output logic              memStb,
  output logic              memWe,
  output logic [1:0]        memGroup,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rdReq,
  output logic              rdLast,
  output logic              tpPtrRst,
  output logic              evPtrRst,
  output logic              boardRst,
  output logic [ADDR_W-1:0] ntaValue,
  output logic [WC_W-1:0]   wcValue,
  output logic              blkWrErr
);

  ctrl_stb_t        stb;
  logic [1:0]       opGrp;
  logic [FLD_W-1:0] opAddr;
  logic             wcZero, wcOne;
  logic [RUN_N-1:0] runStb;

  fecmd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdWord   (cmdWord),
    .dataValid (dataValid),
    .wcZero    (wcZero),
    .wcOne     (wcOne),
    .stb       (stb),
    .opGrp     (opGrp),
    .opAddr    (opAddr)
  );

  fecmd_dpath #(
    .ADDR_W (ADDR_W),
    .WC_W   (WC_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .opGrp    (opGrp),
    .opAddr   (opAddr),
    .dataWord (dataWord),
    .runStb   (runStb),
    .memStb   (memStb),
    .memWe    (memWe),
    .memGroup (memGroup),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .rdReq    (rdReq),
    .rdLast   (rdLast),
    .tpPtrRst (tpPtrRst),
    .evPtrRst (evPtrRst),
    .boardRst (boardRst),
    .ntaValue (ntaValue),
    .wcValue  (wcValue),
    .blkWrErr (blkWrErr),
    .wcZero   (wcZero),
    .wcOne    (wcOne)
  );

  assign runClear     = runStb[0];
  assign runSync      = runStb[1];
  assign runTrigger   = runStb[2];
  assign runReadEvent = runStb[3];
  assign runCalStrobe = runStb[4];

endmodule

// File: rtl/fecmd_chk.sv
module fecmd_chk #(
  parameter int ADDR_W = 8,
  parameter int WC_W   = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [9:0]        cmdWord,
  input logic              dataValid,
  input logic              runClear,
  input logic              runSync,
  input logic              runTrigger,
  input logic              runReadEvent,
  input logic              runCalStrobe,
  input logic              memStb,
  input logic              memWe,
  input logic              rdReq,
  input logic              rdLast,
  input logic              boardRst,
  input logic [ADDR_W-1:0] ntaValue,
  input logic [WC_W-1:0]   wcValue,
  input logic              blkWrErr
);

  localparam logic [WC_W-1:0] WC_UNIT = {{(WC_W-1){1'b0}}, 1'b1};

  // R2
  run_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({runClear, runSync, runTrigger, runReadEvent, runCalStrobe}));

  // R2
  trigger_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    runTrigger |-> ($past(cmdValid) && $past(cmdWord[4:0]) == 5'd3));

  // R5
  rd_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (memStb && !memWe));

  // R5
  last_with_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |-> rdReq);

  // R11
  write_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(dataValid));

  // R8
  err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blkWrErr) |-> ($past(cmdValid) && $past(cmdWord[4:2]) == 3'b111));

  // R7
  wc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wcValue != $past(wcValue)) |->
      ((wcValue == $past(wcValue) - WC_UNIT) || boardRst || $past(dataValid)));

  // R10
  board_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    boardRst |-> (ntaValue == '0 && wcValue == '0 && !blkWrErr));

endmodule

bind fecmd_top fecmd_chk #(.ADDR_W(ADDR_W), .WC_W(WC_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cmdValid     (cmdValid),
  .cmdWord      (cmdWord),
  .dataValid    (dataValid),
  .runClear     (runClear),
  .runSync      (runSync),
  .runTrigger   (runTrigger),
  .runReadEvent (runReadEvent),
  .runCalStrobe (runCalStrobe),
  .memStb       (memStb),
  .memWe        (memWe),
  .rdReq        (rdReq),
  .rdLast       (rdLast),
  .boardRst     (boardRst),
  .ntaValue     (ntaValue),
  .wcValue      (wcValue),
  .blkWrErr     (blkWrErr)
);

// File: tb/sim_fecmd_top.sv
`timescale 1ns/1ps
module sim_fecmd_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [9:0]  cmdWord = '0;
  logic        dataValid = 1'b0;
  logic [15:0] dataWord = '0;

  logic        runClear, runSync, runTrigger, runReadEvent, runCalStrobe;
  logic        memStb, memWe, rdReq, rdLast, tpPtrRst, evPtrRst, boardRst, blkWrErr;
  logic [1:0]  memGroup;
  logic [7:0]  memAddr, ntaValue;
  logic [15:0] memWdata;
  logic [8:0]  wcValue;

  int checks = 0;
  int failures = 0;
  bit armed = 1'b0;

  always #4 clk = ~clk;

  fecmd_top u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .dataValid(dataValid), .dataWord(dataWord),
    .runClear(runClear), .runSync(runSync), .runTrigger(runTrigger),
    .runReadEvent(runReadEvent), .runCalStrobe(runCalStrobe),
    .memStb(memStb), .memWe(memWe), .memGroup(memGroup), .memAddr(memAddr),
    .memWdata(memWdata), .rdReq(rdReq), .rdLast(rdLast),
    .tpPtrRst(tpPtrRst), .evPtrRst(evPtrRst), .boardRst(boardRst),
    .ntaValue(ntaValue), .wcValue(wcValue), .blkWrErr(blkWrErr)
  );

  // ---------------- reference model ----------------
  int    mMode = 0;   // 0 idle, 1 single write waits, 2 block write, 3 block read
  int    mGrp = 0, mAddr = 0, mNta = 0, mWc = 0;
  bit    mErr = 0;
  string mTag = "R1";
  bit [4:0] eRun;
  bit    eStb, eWe, eRd, eLast, eTp, eEv, eBrd;
  int    eGrp, eAddr, eData;
  logic [55:0] expVec = '0;

  task automatic mReadWord();
    eStb = 1; eRd = 1; eGrp = mGrp; eAddr = mNta; eLast = (mWc == 1);
    mNta = (mNta + 1) % 256; mWc = mWc - 1;
  endtask

  always @(posedge clk) begin
    eRun = '0; eStb = 0; eWe = 0; eRd = 0; eLast = 0; eTp = 0; eEv = 0; eBrd = 0;
    eGrp = 0; eAddr = 0; eData = 0;
    if (!rstN) begin
      mMode = 0; mNta = 0; mWc = 0; mErr = 0; mTag = "R1";
    end else begin
      mTag = "R11";
      case (mMode)
        0: if (cmdValid) begin
          if (!cmdWord[4]) begin
            mTag = "R2";
            if (cmdWord[3:0] >= 1 && cmdWord[3:0] <= 5) eRun[cmdWord[3:0]-1] = 1'b1;
          end else if (cmdWord[1:0] != 2'd3) begin
            mTag = "R3";
            mGrp = cmdWord[1:0]; mAddr = cmdWord[9:5];
            if (!cmdWord[3] && !cmdWord[2]) begin
              if (mGrp == 2 && mAddr == 12) begin eTp = 1; mTag = "R10"; end
              else if (mGrp == 2 && mAddr == 24) begin eEv = 1; mTag = "R10"; end
              else if (mGrp == 2 && mAddr == 31) begin
                eBrd = 1; mNta = 0; mWc = 0; mErr = 0; mTag = "R10";
              end else begin
                eStb = 1; eRd = 1; eLast = 1; eGrp = mGrp; eAddr = mAddr; mTag = "R5";
              end
            end else if (cmdWord[3] && !cmdWord[2]) begin
              mMode = 1;
            end else if (!cmdWord[3] && cmdWord[2]) begin
              mTag = "R9";
              if (mWc > 0) begin
                mReadWord();
                if (mWc > 0) mMode = 3;
              end
            end else begin
              mTag = "R8";
              if (mWc == 0) mErr = 1; else mMode = 2;
            end
          end else mTag = "R3";
        end
        1: if (dataValid) begin
          mTag = "R4";
          if (mGrp == 2 && mAddr == 2) begin mNta = dataWord[7:0]; mTag = "R6"; end
          else if (mGrp == 2 && mAddr == 3) begin mWc = dataWord[8:0]; mTag = "R6"; end
          else begin
            eStb = 1; eWe = 1; eGrp = mGrp; eAddr = mAddr; eData = dataWord;
          end
          mMode = 0;
        end
        2: if (dataValid) begin
          mTag = "R7";
          eStb = 1; eWe = 1; eGrp = mGrp; eAddr = mNta; eData = dataWord;
          mNta = (mNta + 1) % 256; mWc = mWc - 1;
          if (mWc == 0) mMode = 0;
        end
        default: begin
          mTag = "R9";
          mReadWord();
          if (mWc == 0) mMode = 0;
        end
      endcase
    end
    expVec = {eRun[0], eRun[1], eRun[2], eRun[3], eRun[4], eStb, eWe,
              eGrp[1:0], eAddr[7:0], eData[15:0], eRd, eLast, eTp, eEv, eBrd,
              mNta[7:0], mWc[8:0], mErr};
  end

  logic [55:0] actVec;
  assign actVec = {runClear, runSync, runTrigger, runReadEvent, runCalStrobe,
                   memStb, memWe, memGroup, memAddr, memWdata, rdReq, rdLast,
                   tpPtrRst, evPtrRst, boardRst, ntaValue, wcValue, blkWrErr};

  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (actVec !== expVec) begin
        failures++;
        $display("FAIL %s cycle compare actual=%h expected=%h", mTag, actVec, expVec);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [9:0] w);
    @(negedge clk); cmdValid = 1'b1; cmdWord = w;
    @(negedge clk); cmdValid = 1'b0; cmdWord = '0;
  endtask

  task automatic sendData(logic [15:0] d);
    @(negedge clk); dataValid = 1'b1; dataWord = d;
    @(negedge clk); dataValid = 1'b0; dataWord = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [9:0] mk(int fld, logic [4:0] op);
    return {fld[4:0], op};
  endfunction

  localparam logic [4:0] RD1 = 5'b10000, WR1 = 5'b11000, RDB = 5'b10100, WRB = 5'b11100;

  task automatic runSeq();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); armed = 1'b1;
    @(negedge clk);
    chk("R1 reset state", {8'd0, actVec[55:32]}, 32'd0);
    chk("R1 reset state low", actVec[31:0], 32'd0);

    // R2: all run-time codes
    for (int g = 0; g < 16; g++) begin
      issue({5'd0, 1'b0, 4'(g)});
      chk("R2 run strobes", {27'd0, runClear, runSync, runTrigger, runReadEvent, runCalStrobe},
          (g >= 1 && g <= 5) ? (32'd16 >> (g - 1)) : 32'd0);
    end
    issue(10'h003); issue(10'h003);

    // R3: group 3 ignored
    issue(mk(5, 5'b10011));
    chk("R3 group3 ignored", {31'd0, memStb}, 32'd0);

    // R5: single read
    issue(mk(7, RD1 | 5'd0));
    chk("R5 single read", {28'd0, memStb, memWe, rdReq, rdLast}, 32'hB);
    chk("R5 read addr", {24'd0, memAddr}, 32'd7);

    // R4 / R11: single write with command offered while waiting
    issue(mk(9, WR1 | 5'd1));
    idle(2);
    issue(10'h003);
    chk("R11 cmd ignored while waiting", {31'd0, runTrigger}, 32'd0);
    sendData(16'hBEEF);
    chk("R4 write strobe", {30'd0, memStb, memWe}, 32'd3);
    chk("R4 write addr/group", {22'd0, memGroup, memAddr}, {22'd0, 2'd1, 8'd9});
    chk("R4 write data", {16'd0, memWdata}, 32'hBEEF);
    sendData(16'h1234);
    chk("R11 data ignored when idle", {31'd0, memStb}, 32'd0);

    // R6: load pointer and counter
    issue(mk(2, WR1 | 5'd2)); sendData(16'h00FE);
    chk("R6 nta load", {24'd0, ntaValue}, 32'hFE);
    chk("R6 no mem strobe", {31'd0, memStb}, 32'd0);
    issue(mk(3, WR1 | 5'd2)); sendData(16'h0004);
    chk("R6 wc load", {23'd0, wcValue}, 32'd4);

    // R7: block write across the address wrap
    issue(mk(0, WRB | 5'd0));
    sendData(16'hA000); idle(1);
    sendData(16'hA001);
    chk("R7 second word addr", {24'd0, memAddr}, 32'hFF);
    sendData(16'hA002);
    chk("R7 wrap addr", {24'd0, memAddr}, 32'h00);
    idle(3);
    sendData(16'hA003);
    chk("R7 last addr", {24'd0, memAddr}, 32'h01);
    chk("R7 nta after", {24'd0, ntaValue}, 32'h02);
    chk("R7 wc after", {23'd0, wcValue}, 32'd0);

    // R8: block write with empty counter
    issue(mk(0, WRB | 5'd1));
    chk("R8 err set", {31'd0, blkWrErr}, 32'd1);
    sendData(16'h5555);
    chk("R8 nothing written", {31'd0, memStb}, 32'd0);

    // R9 / R11: block read of three with a command offered mid-stream
    issue(mk(3, WR1 | 5'd2)); sendData(16'h0003);
    @(negedge clk); cmdValid = 1'b1; cmdWord = mk(0, RDB | 5'd1);
    @(negedge clk); cmdWord = mk(6, RD1 | 5'd0);
    chk("R9 first word", {22'd0, memGroup, memAddr}, {22'd0, 2'd1, 8'd2});
    @(negedge clk); cmdValid = 1'b0; cmdWord = '0;
    idle(3);
    chk("R9 nta after read", {24'd0, ntaValue}, 32'd5);
    issue(mk(0, RDB | 5'd1));
    chk("R9 empty read", {31'd0, memStb}, 32'd0);
    issue(mk(3, WR1 | 5'd2)); sendData(16'h0001);
    issue(mk(0, RDB | 5'd0));
    chk("R9 single-word block read", {29'd0, memStb, rdReq, rdLast}, 32'd7);

    // R10: pointer and board resets
    issue(mk(12, RD1 | 5'd2));
    chk("R10 tp reset", {30'd0, tpPtrRst, rdReq}, 32'd2);
    issue(mk(24, RD1 | 5'd2));
    chk("R10 ev reset", {30'd0, evPtrRst, rdReq}, 32'd2);
    issue(mk(31, RD1 | 5'd2));
    chk("R10 board reset", {31'd0, boardRst}, 32'd1);
    chk("R10 cleared", {14'd0, ntaValue, wcValue, blkWrErr}, 32'd0);
    idle(4);
  endtask

  initial begin
    fork
      runSeq();
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule